// File: doc/BRIEF.md
# Line Drive Soft Start/Stop Sequencer

This block produces the horizontal drive pulse for a line deflection stage. It also runs the power-up and standby shutdown sequence of that stage. The drive pin is open-collector, so a low level turns the output transistor on and a high level turns it off. When the block is enabled it starts the drive at twice the line rate with a short on-portion. After a settling time it moves to the normal line rate and duty cycle. When standby is requested it returns to the doubled rate and first forces the RGB drive to maximum, then to minimum. This discharges the picture tube. After that the drive stops.

All timing is counted in system clock cycles, and every duration is a parameter. With a 1 MHz clock the defaults give 64 cycles per normal line period, 32 cycles per doubled period, a 50 ms start phase, a 100 ms discharge phase and a 50 ms tail. In normal operation a line-rate reference tick can close a period early when it falls near the period's end. This keeps the drive aligned with the line timing.

Top module: `line_drive_seq`

## Requirements
- R1: After reset, and whenever the sequencer is off, `hDrive` is 1, `rgbOvr` is 2'b00 and `normalRate` is 0. This holds for as long as `runEn` stays low.
- R2: When `runEn` is sampled high in the off state, a start phase begins on the next cycle. This also applies after a completed shutdown. Each period lasts NORM_PERIOD/2 cycles. `hDrive` is 1 for the first (NORM_PERIOD/2)*3/4 cycles of the period and 0 for the rest.
- R3: Once the start phase has lasted at least START_CYC cycles, it ends at the next period end and the normal phase begins. Each normal period lasts NORM_PERIOD cycles. `hDrive` is 1 for the first NORM_PERIOD*45/100 cycles and 0 for the rest. `normalRate` is 1 only in this phase.
- R4: In the normal phase, `runEn` is sampled at each period end. If it is low there, the discharge phase begins on the next cycle with a fresh doubled-rate period, and `rgbOvr` becomes 2'b01 (force RGB to maximum). Before that period end, `rgbOvr` stays 2'b00.
- R5: If `runEn` is sampled low during the start phase, the discharge phase begins on the next cycle with `rgbOvr` = 2'b01. The doubled-rate period already running continues without restarting.
- R6: `rgbOvr` holds 2'b01 for exactly DISCH_CYC cycles. It then becomes 2'b10 (force RGB to minimum), and the doubled-rate drive continues.
- R7: Once `rgbOvr` has been 2'b10 for at least TAIL_CYC cycles, the drive stops at the next period end and all outputs return to their off values. `runEn` has no effect while `rgbOvr` is nonzero.
- R8: In the normal phase, a `lineTick` sampled while the period has SYNC_WIN or fewer cycles left ends the period in that cycle, so the next cycle starts a new period with `hDrive` = 1. A tick sampled at any other time, or in any other phase, has no effect.
- R9: The period length and duty cycle change only where a new period begins. The last doubled-rate period before the normal phase ends with its full low portion of (NORM_PERIOD/2)/4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | 1 = run the deflection, 0 = standby request |
| lineTick | input | 1 | Line-rate reference tick, one cycle wide |
| hDrive | output | 1 | Drive pin level: 0 = transistor on, 1 = off |
| rgbOvr | output | 2 | RGB override: 00 none, 01 force maximum, 10 force minimum |
| normalRate | output | 1 | 1 while running at the normal line rate |

## Verification
The assertions check on every cycle the rules that hold at all times. The normal phase is left only at a period end. The minimum override comes only after the maximum override. The drive stops only from the tail phase. The period counter stays in range and restarts whenever the rate changes. Only the bench scenarios can show the actual durations: the start, discharge and tail lengths, the duty cycle at each rate, the exact cycle at which a standby request takes effect in each phase, and the window in which a line tick is accepted. The bench shows these by comparing every output cycle against its own reference and by measuring pulse runs and delays directly.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_START  = 3'd1,
    PH_NORMAL = 3'd2,
    PH_DISCH  = 3'd3,
    PH_TAIL   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    RGB_NONE = 2'b00,
    RGB_MAX  = 2'b01,
    RGB_MIN  = 2'b10
  } rgb_e;

  // strobes from the sequencer to the pulse datapath
  typedef struct packed {
    logic driveEn;  // pulse train running
    logic dblRate;  // doubled line rate
    logic syncEn;   // reference tick may close a period
  } pulse_ctl_t;

endpackage

// File: rtl/ldrv_ctrl.sv
module ldrv_ctrl
  import ldrv_pkg::*;
#(
  parameter int START_CYC = 50000,
  parameter int DISCH_CYC = 100000,
  parameter int TAIL_CYC  = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       periodEnd,
  output pulse_ctl_t ctl,
  output rgb_e       rgbSel,
  output logic       normalRate
);

  localparam int TMAX_A = (START_CYC > DISCH_CYC) ? START_CYC : DISCH_CYC;
  localparam int TMAX   = (TMAX_A > TAIL_CYC) ? TMAX_A : TAIL_CYC;
  localparam int TW     = $clog2(TMAX + 1);

  phase_e         ph, phNext;
  logic [TW-1:0]  timer;
  logic           timerDone;

  // phase timer: cycles spent in the current phase, saturating
  always_comb begin
    case (ph)
      PH_START: timerDone = (timer >= TW'(START_CYC - 1));
      PH_DISCH: timerDone = (timer >= TW'(DISCH_CYC - 1));
      PH_TAIL:  timerDone = (timer >= TW'(TAIL_CYC - 1));
      default:  timerDone = 1'b0;
    endcase
  end

  always_comb begin
    phNext = ph;
    case (ph)
      PH_OFF:    if (runEn) phNext = PH_START;
      PH_START: begin
        if (!runEn)                      phNext = PH_DISCH;
        else if (periodEnd && timerDone) phNext = PH_NORMAL;
      end
      PH_NORMAL: if (!runEn && periodEnd) phNext = PH_DISCH;
      PH_DISCH:  if (timerDone) phNext = PH_TAIL;
      PH_TAIL:   if (periodEnd && timerDone) phNext = PH_OFF;
      default:   phNext = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph    <= PH_OFF;
      timer <= '0;
    end else begin
      ph <= phNext;
      if (phNext != ph)             timer <= '0;
      else if (timer != TW'(TMAX))  timer <= timer + 1'b1;
    end
  end

  always_comb begin
    ctl.driveEn = (ph != PH_OFF);
    ctl.dblRate = (ph != PH_NORMAL);
    ctl.syncEn  = (ph == PH_NORMAL);
    case (ph)
      PH_DISCH: rgbSel = RGB_MAX;
      PH_TAIL:  rgbSel = RGB_MIN;
      default:  rgbSel = RGB_NONE;
    endcase
    normalRate = (ph == PH_NORMAL);
  end

  AST_NORM_EXIT_AT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ph) == PH_NORMAL && ph != PH_NORMAL) |-> $past(periodEnd)); // R4

  AST_MIN_AFTER_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (rgbSel == RGB_MIN && $past(rgbSel) != RGB_MIN) |-> $past(rgbSel) == RGB_MAX); // R6

  AST_STOP_FROM_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ph) != PH_OFF && ph == PH_OFF) |-> $past(ph) == PH_TAIL); // R7

  AST_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ph) != PH_START && ph == PH_START) |-> $past(ph) == PH_OFF && $past(runEn)); // R2

endmodule

// File: rtl/ldrv_pulse.sv
module ldrv_pulse
  import ldrv_pkg::*;
#(
  parameter int NORM_PERIOD = 64,
  parameter int SYNC_WIN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  pulse_ctl_t ctl,
  input  logic       lineTick,
  output logic       periodEnd,
  output logic       hDrive
);

  localparam int DBL_PERIOD = NORM_PERIOD / 2;
  localparam int CW         = $clog2(NORM_PERIOD);
  localparam int NORM_HI    = NORM_PERIOD * 45 / 100;
  localparam int DBL_HI     = DBL_PERIOD * 3 / 4;

  logic [CW-1:0] cnt;
  logic [CW-1:0] curLast, curHi;
  logic          syncHit;

  assign curLast   = ctl.dblRate ? CW'(DBL_PERIOD - 1) : CW'(NORM_PERIOD - 1);
  assign curHi     = ctl.dblRate ? CW'(DBL_HI) : CW'(NORM_HI);
  assign syncHit   = ctl.syncEn && lineTick && (cnt >= CW'(NORM_PERIOD - SYNC_WIN));
  assign periodEnd = ctl.driveEn && ((cnt == curLast) || syncHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (!ctl.driveEn)   cnt <= '0;
    else if (periodEnd)      cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // off portion first, then the on (low) portion of each period
  assign hDrive = !ctl.driveEn || (cnt < curHi);

  AST_RATE_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dblRate != $past(ctl.dblRate)) |-> cnt == '0); // R9

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= curLast); // R2

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.driveEn |=> (cnt == '0) || ctl.driveEn); // R1

endmodule

// File: rtl/line_drive_seq.sv
module line_drive_seq
  import ldrv_pkg::*;
#(
  parameter int NORM_PERIOD = 64,
  parameter int SYNC_WIN    = 4,
  parameter int START_CYC   = 50000,
  parameter int DISCH_CYC   = 100000,
  parameter int TAIL_CYC    = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       lineTick,
  output logic       hDrive,
  output logic [1:0] rgbOvr,
  output logic       normalRate
);

  pulse_ctl_t ctl;
  rgb_e       rgbSel;
  logic       periodEnd;

  ldrv_ctrl #(
    .START_CYC(START_CYC),
    .DISCH_CYC(DISCH_CYC),
    .TAIL_CYC (TAIL_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .periodEnd (periodEnd),
    .ctl       (ctl),
    .rgbSel    (rgbSel),
    .normalRate(normalRate)
  );

  ldrv_pulse #(
    .NORM_PERIOD(NORM_PERIOD),
    .SYNC_WIN   (SYNC_WIN)
  ) u_pulse (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .lineTick (lineTick),
    .periodEnd(periodEnd),
    .hDrive   (hDrive)
  );

  assign rgbOvr = rgbSel;

endmodule

// File: tb/line_drive_seq_bench.sv
module line_drive_seq_bench;

  localparam int NORM  = 64;
  localparam int DBL   = NORM / 2;
  localparam int SW    = 4;
  localparam int TSTA  = 300;
  localparam int TDIS  = 500;
  localparam int TTAIL = 250;
  localparam int NHI   = NORM * 45 / 100;
  localparam int DHI   = DBL * 3 / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic lineTick = 1'b0;
  logic hDrive;
  logic [1:0] rgbOvr;
  logic normalRate;

  int nChk = 0;
  int nFail = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_drive_seq #(
    .NORM_PERIOD(NORM), .SYNC_WIN(SW),
    .START_CYC(TSTA), .DISCH_CYC(TDIS), .TAIL_CYC(TTAIL)
  ) u_line_drive_seq (
    .clk(clk), .rstN(rstN), .runEn(runEn), .lineTick(lineTick),
    .hDrive(hDrive), .rgbOvr(rgbOvr), .normalRate(normalRate)
  );

  // reference: phase 0 off, 1 start, 2 normal, 3 discharge, 4 tail
  int mPh = 0, mCnt = 0, mTim = 0;

  function automatic int perOf(int ph);
    return (ph == 2) ? NORM : DBL;
  endfunction
  function automatic int hiOf(int ph);
    return (ph == 2) ? NHI : DHI;
  endfunction
  function automatic int expH(int ph, int c);
    return (ph == 0) ? 1 : ((c < hiOf(ph)) ? 1 : 0);
  endfunction
  function automatic int expR(int ph);
    return (ph == 3) ? 1 : ((ph == 4) ? 2 : 0);
  endfunction
  function automatic string tagOf(int ph);
    case (ph)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh <= 0; mCnt <= 0; mTim <= 0;
    end else begin
      bit wrap;
      int nPh;
      wrap = (mPh != 0) && ((mCnt == perOf(mPh) - 1) ||
             (mPh == 2 && lineTick && mCnt >= NORM - SW));
      nPh = mPh;
      case (mPh)
        0: if (runEn) nPh = 1;
        1: if (!runEn) nPh = 3; else if (wrap && mTim >= TSTA - 1) nPh = 2;
        2: if (!runEn && wrap) nPh = 3;
        3: if (mTim >= TDIS - 1) nPh = 4;
        4: if (wrap && mTim >= TTAIL - 1) nPh = 0;
        default: nPh = 0;
      endcase
      mCnt <= (mPh == 0 || wrap) ? 0 : mCnt + 1;
      mTim <= (nPh != mPh) ? 0 : mTim + 1;
      mPh  <= nPh;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      chk({tagOf(mPh), " hDrive"}, int'(hDrive), expH(mPh, mCnt));
      chk({tagOf(mPh), " rgbOvr"}, int'(rgbOvr), expR(mPh));
      chk({tagOf(mPh), " normalRate"}, int'(normalRate), (mPh == 2) ? 1 : 0);
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitFor(int ph, int c);
    while (!(mPh == ph && mCnt == c)) @(negedge clk);
  endtask

  // count off cycles across one full period starting now
  task automatic dutyCheck(string tag, int per, int expHi);
    int hi = 0;
    for (int i = 0; i < per; i++) begin
      if (hDrive) hi++;
      @(negedge clk);
    end
    chk(tag, hi, expHi);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int k, lowRun;
    void'($urandom(32'd2024));
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;

    // R1 reset / idle state
    chk("R1 reset hDrive", int'(hDrive), 1);
    chk("R1 reset rgbOvr", int'(rgbOvr), 0);
    chk("R1 reset normalRate", int'(normalRate), 0);
    waitCyc(20);
    chk("R1 idle hDrive", int'(hDrive), 1);

    // R2 start at doubled rate, R3 timing, R9 full low before change
    runEn = 1'b1;
    @(negedge clk);
    dutyCheck("R2 start duty", DBL, DHI);
    k = 1 + DBL; lowRun = 0;
    while (!normalRate && k < 5000) begin
      lowRun = hDrive ? 0 : lowRun + 1;
      @(negedge clk); k++;
    end
    chk("R3 start length", k, 1 + ((TSTA + DBL - 1) / DBL) * DBL);
    chk("R9 last low run", lowRun, DBL - DHI);
    dutyCheck("R3 normal duty", NORM, NHI);

    // R8 tick inside window closes the period
    waitFor(2, NORM - 2);
    lineTick = 1'b1; @(negedge clk); lineTick = 1'b0;
    chk("R8 tick in window", int'(hDrive), 1);
    waitFor(2, 40);
    lineTick = 1'b1; @(negedge clk); lineTick = 1'b0;
    chk("R8 tick outside window", int'(hDrive), 0);
    waitFor(2, NORM - 1 - SW);
    lineTick = 1'b1; @(negedge clk); lineTick = 1'b0;
    chk("R8 tick just before window", int'(hDrive), 0);

    // R4 standby in normal waits for period end
    waitFor(2, 20);
    runEn = 1'b0;
    k = 0;
    while (rgbOvr != 2'b01 && k < 200) begin @(negedge clk); k++; end
    chk("R4 standby delay", k, NORM - 20);
    chk("R4 doubled rate after standby", int'(normalRate), 0);

    // R6 discharge length, with runEn toggling ignored (R7)
    k = 0;
    while (rgbOvr == 2'b01 && k < 5000) begin
      if (k == 100) runEn = 1'b1;
      if (k == 150) runEn = 1'b0;
      @(negedge clk); k++;
    end
    chk("R6 discharge length", k, TDIS);
    chk("R6 min override", int'(rgbOvr), 2);
    k = 0;
    while (rgbOvr == 2'b10 && k < 5000) begin @(negedge clk); k++; end
    chk("R7 tail ends at boundary", (k >= TTAIL && k < TTAIL + DBL) ? 1 : 0, 1);
    waitCyc(40);
    chk("R7 stopped hDrive", int'(hDrive), 1);
    chk("R7 stopped rgbOvr", int'(rgbOvr), 0);

    // R5 standby during start keeps the running period
    runEn = 1'b1;
    waitFor(1, 10);
    runEn = 1'b0;
    @(negedge clk);
    chk("R5 immediate discharge", int'(rgbOvr), 1);
    k = 1;
    while (hDrive && k < 100) begin @(negedge clk); k++; end
    chk("R5 period continues", k, DHI - 10);
    while (mPh != 0) @(negedge clk);
    waitCyc(5);

    // random episodes against the reference
    for (int ep = 0; ep < 12; ep++) begin
      int runLen, offLen;
      runLen = 50 + int'($urandom % 1500);
      runEn = 1'b1;
      for (int i = 0; i < runLen; i++) begin
        lineTick = ($urandom % 6) == 0;
        @(negedge clk);
      end
      runEn = 1'b0;
      offLen = int'($urandom % 1200);
      for (int i = 0; i < offLen; i++) begin
        lineTick = ($urandom % 6) == 0;
        if (mPh >= 3) runEn = ($urandom % 4) == 0;
        else runEn = 1'b0;
        @(negedge clk);
      end
      lineTick = 1'b0;
      runEn = 1'b0;
      while (mPh != 0) @(negedge clk);
      waitCyc(3);
    end

    finishRun();
  end

endmodule